// File: doc/BRIEF.md
# Load/Store Address Generator

This block executes the memory-class instructions of a 32-bit register machine. When it is idle it accepts one instruction word, together with the values of the registers that word names, and starts work. It forms an offset from an index register, a short signed constant or a long signed constant. It adds that offset to a base register, either before the bus access (pre-indexing) or after it (post-indexing). It then makes one bus access of byte, 16-bit or 32-bit size.

For a load, the block takes the addressed lanes from the bus read word, zero-extends them, and writes the result to the transfer register. For a store, it copies the transfer register into every lane of matching size on the bus write data. The updated base address can optionally be written back through a second register write port.

If the condition register is zero, the instruction is skipped. An invalid size or a misaligned address raises a fault instead of an access.

The controller has five states:

- `ST_IDLE` waits for `issue_valid` and takes **accept** to `ST_EVAL`.
- `ST_EVAL` checks the predicate and alignment. From there, **skip** goes back to `ST_IDLE`, **reject** goes to `ST_FAULT`, and **launch** goes to `ST_ACCESS`.
- `ST_ACCESS` holds the bus request until `bus_wait` is low, then takes **complete** to `ST_COMMIT`.
- `ST_COMMIT` performs the register writes and takes **retire** back to `ST_IDLE`.
- `ST_FAULT` pulses the fault and takes **abort** back to `ST_IDLE`.

Top module: `ls_agen`

## Requirements
- R1: The offset is selected by instruction bits. If bit 13 is 1, the offset is bits 12:0 as a sign-extended 13-bit constant. If bit 13 is 0 and bit 4 is 1, the offset is bits 3:0 as a sign-extended 4-bit constant. Otherwise the offset is `index_val`, the value of the register in bits 3:0.
- R2: Bit 28 selects the indexing mode. When it is 1 (pre-indexing), the bus address is base+offset. When it is 0 (post-indexing), the bus address is `base_val` unchanged. The base register number is in bits 19:16.
- R3: When bit 29 is 1, base+offset is written to the base register on the write-back port in the commit cycle. When bit 29 is 0, there is no write-back.
- R4: Bits 15:14 give the size, and `bus_width` carries it: 0 = byte, 1 = 16-bit, 2 = 32-bit. Bus lane k holds bits 8k+7:8k, and the lanes used are those at `bus_addr[1:0]`. Byte and 16-bit loads are zero-extended into the transfer register, whose number is in bits 27:24.
- R5: Bit 30 selects the direction: 0 = load and 1 = store. A store drives `bus_we`=1. Its write data is the low byte copied four times, the low half copied twice, or the whole word. A store makes no transfer-register write.
- R6: Size 3, a 16-bit access at an odd address, or a 32-bit access at an address not a multiple of 4 pulses `align_fault` with `done`. No bus request and no register write follow.
- R7: If `cond_val` (the register in bits 23:20) is zero, the instruction makes no access and no register write. It only pulses `done` one cycle after acceptance.
- R8: `bus_req` stays high with a stable address while `bus_wait` is high. Register writes occur only in the cycle after a bus cycle with `bus_req` high and `bus_wait` low.
- R9: For a load with write-back whose transfer register equals its base register, only the loaded data is written. The write-back port stays idle.
- R10: An instruction is accepted only while `busy` is low. `busy` stays high from acceptance until `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | Instruction offered |
| instr | input | 32 | Memory-class instruction word |
| base_val | input | 32 | Value of the base register |
| index_val | input | 32 | Value of the index register |
| xfer_val | input | 32 | Value of the transfer register |
| cond_val | input | 32 | Value of the condition register |
| busy | output | 1 | Instruction in progress |
| bus_req | output | 1 | Bus access request |
| bus_addr | output | 32 | Byte address of the access |
| bus_width | output | 2 | Access size code |
| bus_we | output | 1 | 1 = write access |
| bus_wdata | output | 32 | Lane-replicated store data |
| bus_rdata | input | 32 | Read word from the bus |
| bus_wait | input | 1 | Stretch the current access |
| rd_we | output | 1 | Transfer-register write enable |
| rd_addr | output | 4 | Transfer-register number |
| rd_data | output | 32 | Zero-extended load data |
| wb_we | output | 1 | Base write-back enable |
| wb_addr | output | 4 | Base-register number |
| wb_data | output | 32 | Updated base address |
| align_fault | output | 1 | Size or alignment fault pulse |
| done | output | 1 | Instruction finished pulse |

## Verification
The assertions assume that `issue_valid` is only raised while `busy` is low. They also assume that `bus_rdata` reflects the word at the current address during the completing bus cycle.

The bench driver meets both assumptions. It waits for `busy` to drop before offering a word, and it computes read data combinationally from `bus_addr`. `bus_wait` is toggled pseudo-randomly in every cycle, including cycles with no request, so access stretches of different lengths occur.

// File: rtl/ls_agen_pkg.sv
package ls_agen_pkg;

    localparam int REG_IDX_W = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EVAL,
        ST_ACCESS,
        ST_COMMIT,
        ST_FAULT
    } agen_state_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_LONG = 2'd2,
        SZ_BAD  = 2'd3
    } xfer_size_e;

    typedef struct packed {
        logic                 is_store;
        logic                 writeback;
        logic                 pre_index;
        logic [REG_IDX_W-1:0] xfer_reg;
        logic [REG_IDX_W-1:0] cond_reg;
        logic [REG_IDX_W-1:0] base_reg;
        xfer_size_e           size;
        logic                 long_imm;
        logic                 short_imm;
        logic [12:0]          imm13;
        logic [3:0]           imm4;
    } mem_op_t;

    function automatic mem_op_t decode_mem(input logic [31:0] w);
        mem_op_t d;
        d.is_store  = w[30];
        d.writeback = w[29];
        d.pre_index = w[28];
        d.xfer_reg  = w[27:24];
        d.cond_reg  = w[23:20];
        d.base_reg  = w[19:16];
        d.size      = xfer_size_e'(w[15:14]);
        d.long_imm  = w[13];
        d.short_imm = w[4];
        d.imm13     = w[12:0];
        d.imm4      = w[3:0];
        return d;
    endfunction

endpackage

// File: rtl/ls_agen_addr.sv
module ls_agen_addr
    import ls_agen_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  mem_op_t         op,
    input  logic [XLEN-1:0] base_val,
    input  logic [XLEN-1:0] index_val,
    output logic [XLEN-1:0] acc_addr,
    output logic [XLEN-1:0] next_base,
    output logic            bad_access
);
    logic [XLEN-1:0] offset;

    always_comb begin
        if (op.long_imm)
            offset = {{(XLEN-13){op.imm13[12]}}, op.imm13};
        else if (op.short_imm)
            offset = {{(XLEN-4){op.imm4[3]}}, op.imm4};
        else
            offset = index_val;
    end

    assign next_base = base_val + offset;
    assign acc_addr  = op.pre_index ? next_base : base_val;

    always_comb begin
        unique case (op.size)
            SZ_BYTE: bad_access = 1'b0;
            SZ_HALF: bad_access = acc_addr[0];
            SZ_LONG: bad_access = |acc_addr[1:0];
            SZ_BAD:  bad_access = 1'b1;
        endcase
    end
endmodule

// File: rtl/ls_agen_lanes.sv
module ls_agen_lanes
    import ls_agen_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  xfer_size_e          size,
    input  logic [LO_W-1:0]     addr_lo,
    input  logic [XLEN-1:0]     rdata,
    input  logic [XLEN-1:0]     xfer_val,
    output logic [XLEN-1:0]     load_data,
    output logic [XLEN-1:0]     store_data
);
    localparam int LANES = XLEN / 8;
    localparam int LO_W  = $clog2(LANES);

    logic [XLEN-1:0] shifted;
    assign shifted = rdata >> {addr_lo, 3'b000};

    always_comb begin
        unique case (size)
            SZ_BYTE: load_data = {{(XLEN-8){1'b0}},  shifted[7:0]};
            SZ_HALF: load_data = {{(XLEN-16){1'b0}}, shifted[15:0]};
            default: load_data = shifted;
        endcase
    end

    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        always_comb begin
            unique case (size)
                SZ_BYTE: store_data[8*ln +: 8] = xfer_val[7:0];
                SZ_HALF: store_data[8*ln +: 8] = xfer_val[8*(ln%2) +: 8];
                default: store_data[8*ln +: 8] = xfer_val[8*ln +: 8];
            endcase
        end
    end
endmodule

// File: rtl/ls_agen.sv
module ls_agen
    import ls_agen_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 issue_valid,
    input  logic [31:0]          instr,
    input  logic [XLEN-1:0]      base_val,
    input  logic [XLEN-1:0]      index_val,
    input  logic [XLEN-1:0]      xfer_val,
    input  logic [XLEN-1:0]      cond_val,
    output logic                 busy,
    output logic                 bus_req,
    output logic [XLEN-1:0]      bus_addr,
    output logic [1:0]           bus_width,
    output logic                 bus_we,
    output logic [XLEN-1:0]      bus_wdata,
    input  logic [XLEN-1:0]      bus_rdata,
    input  logic                 bus_wait,
    output logic                 rd_we,
    output logic [REG_IDX_W-1:0] rd_addr,
    output logic [XLEN-1:0]      rd_data,
    output logic                 wb_we,
    output logic [REG_IDX_W-1:0] wb_addr,
    output logic [XLEN-1:0]      wb_data,
    output logic                 align_fault,
    output logic                 done
);
    localparam int LO_W = $clog2(XLEN / 8);

    agen_state_e     state_q, state_d;
    logic [31:0]     instr_q;
    logic [XLEN-1:0] base_q, index_q, xfer_q, rdata_q;
    logic            skip_q;
    mem_op_t         op;
    logic [XLEN-1:0] acc_addr, next_base, load_data, store_data;
    logic            bad_access, same_reg_load;

    assign op = decode_mem(instr_q);

    ls_agen_addr #(.XLEN(XLEN)) u_addr (
        .op        (op),
        .base_val  (base_q),
        .index_val (index_q),
        .acc_addr  (acc_addr),
        .next_base (next_base),
        .bad_access(bad_access)
    );

    ls_agen_lanes #(.XLEN(XLEN)) u_lanes (
        .size      (op.size),
        .addr_lo   (acc_addr[LO_W-1:0]),
        .rdata     (rdata_q),
        .xfer_val  (xfer_q),
        .load_data (load_data),
        .store_data(store_data)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // operand capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            instr_q <= '0;
            base_q  <= '0;
            index_q <= '0;
            xfer_q  <= '0;
            skip_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            if (state_q == ST_IDLE && issue_valid) begin
                instr_q <= instr;
                base_q  <= base_val;
                index_q <= index_val;
                xfer_q  <= xfer_val;
                skip_q  <= (cond_val == '0);
            end
            if (state_q == ST_ACCESS && !bus_wait)
                rdata_q <= bus_rdata;
        end
    end

    // transitions: accept, skip, reject, launch, complete, retire, abort
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (issue_valid) state_d = ST_EVAL;
            ST_EVAL: begin
                if (skip_q)          state_d = ST_IDLE;
                else if (bad_access) state_d = ST_FAULT;
                else                 state_d = ST_ACCESS;
            end
            ST_ACCESS: if (!bus_wait) state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_IDLE;
            ST_FAULT:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    assign same_reg_load = !op.is_store && (op.xfer_reg == op.base_reg);

    // outputs
    always_comb begin
        busy        = (state_q != ST_IDLE);
        bus_req     = (state_q == ST_ACCESS);
        bus_addr    = acc_addr;
        bus_width   = op.size;
        bus_we      = op.is_store;
        bus_wdata   = store_data;
        rd_we       = (state_q == ST_COMMIT) && !op.is_store;
        rd_addr     = op.xfer_reg;
        rd_data     = load_data;
        wb_we       = (state_q == ST_COMMIT) && op.writeback && !same_reg_load;
        wb_addr     = op.base_reg;
        wb_data     = next_base;
        align_fault = (state_q == ST_FAULT);
        done        = (state_q == ST_COMMIT) || (state_q == ST_FAULT)
                   || (state_q == ST_EVAL && skip_q);
    end

    // R6: no request leaves the block with a bad size or misaligned address
    a_r6_half_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_width == 2'd1) |-> !bus_addr[0]);
    a_r6_long_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_width == 2'd2) |-> (bus_addr[1:0] == 2'b00));
    a_r6_no_bad_size: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (bus_width != 2'd3));
    a_r6_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        align_fault |-> (!rd_we && !wb_we && !bus_req));
    // R8: request held stable while stretched; writes only after completion
    a_r8_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_wait) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));
    a_r8_write_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_we || wb_we) |-> $past(bus_req && !bus_wait));
    // R9: both ports never target the same register
    a_r9_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_we && wb_we) |-> (rd_addr != wb_addr));
    // R10: done ends a busy period
    a_r10_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
    a_r10_one_event: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bus_req, done}));
endmodule

// File: tb/ls_agen_tb_top.sv
module ls_agen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic [31:0] instr = '0, base_val = '0, index_val = '0, xfer_val = '0, cond_val = '0;
    logic        busy, bus_req, bus_we, bus_wait, rd_we, wb_we, align_fault, done;
    logic [31:0] bus_addr, bus_wdata, bus_rdata, rd_data, wb_data;
    logic [1:0]  bus_width;
    logic [3:0]  rd_addr, wb_addr;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    function automatic logic [31:0] memf(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
    endfunction

    assign bus_rdata = memf({bus_addr[31:2], 2'b00});

    ls_agen dut_i (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .instr(instr),
        .base_val(base_val), .index_val(index_val), .xfer_val(xfer_val),
        .cond_val(cond_val), .busy(busy), .bus_req(bus_req), .bus_addr(bus_addr),
        .bus_width(bus_width), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_wait(bus_wait), .rd_we(rd_we), .rd_addr(rd_addr),
        .rd_data(rd_data), .wb_we(wb_we), .wb_addr(wb_addr), .wb_data(wb_data),
        .align_fault(align_fault), .done(done)
    );

    typedef struct {
        bit          fault;
        bit          rwe;
        logic [3:0]  ra;
        logic [31:0] rd;
        bit          wwe;
        logic [3:0]  wa;
        logic [31:0] wd;
        string       tag;
    } res_t;

    typedef struct {
        logic [31:0] addr;
        logic [1:0]  width;
        bit          we;
        logic [31:0] wdata;
        string       tag;
    } bus_t;

    res_t res_q[$];
    bus_t bus_q[$];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input bit st, input bit wb, input bit pre,
                                       input logic [3:0] t, input logic [3:0] e,
                                       input logic [3:0] f, input logic [1:0] sz,
                                       input bit lng, input bit sht, input logic [12:0] lo);
        logic [12:0] low;
        low = lng ? lo : {8'b0, sht, lo[3:0]};
        return {1'b1, st, wb, pre, t, e, f, sz, lng, low};
    endfunction

    task automatic issue(input logic [31:0] iw, input logic [31:0] b, input logic [31:0] ix,
                         input logic [31:0] xv, input logic [31:0] cv, input string tag);
        res_t r;
        bus_t bi;
        logic [31:0] off, sum, a, word;
        logic [1:0]  sz;
        bit bad;
        if (iw[13])     off = 32'($signed(iw[12:0]));
        else if (iw[4]) off = 32'($signed(iw[3:0]));
        else            off = ix;
        sum = b + off;
        a   = iw[28] ? sum : b;
        sz  = iw[15:14];
        r = '{fault: 1'b0, rwe: 1'b0, ra: 4'd0, rd: 32'd0, wwe: 1'b0, wa: 4'd0, wd: 32'd0, tag: tag};
        if (cv != 0) begin
            bad = (sz == 2'd3) || (sz == 2'd1 && a[0]) || (sz == 2'd2 && a[1:0] != 2'b00);
            if (bad) r.fault = 1'b1;
            else begin
                bi.addr = a; bi.width = sz; bi.we = iw[30]; bi.tag = tag;
                case (sz)
                    2'd0:    bi.wdata = {4{xv[7:0]}};
                    2'd1:    bi.wdata = {2{xv[15:0]}};
                    default: bi.wdata = xv;
                endcase
                r.wa = iw[19:16]; r.wd = sum;
                if (iw[30]) r.wwe = iw[29];
                else begin
                    word = memf({a[31:2], 2'b00}) >> (8 * a[1:0]);
                    r.rwe = 1'b1; r.ra = iw[27:24];
                    r.rd  = (sz == 2'd0) ? (word & 32'hFF) : (sz == 2'd1) ? (word & 32'hFFFF) : word;
                    r.wwe = iw[29] && (iw[27:24] != iw[19:16]);
                end
                bus_q.push_back(bi);
            end
        end
        res_q.push_back(r);
        @(negedge clk);
        while (busy) @(negedge clk);
        instr = iw; base_val = b; index_val = ix; xfer_val = xv; cond_val = cv;
        issue_valid = 1'b1;
        @(negedge clk);
        issue_valid = 1'b0;
        // R10: accepted word keeps the block busy
        chk(busy == 1'b1, {"R10 busy after accept ", tag}, 32'(busy), 32'd1);
    endtask

    // bus wait pattern
    initial begin
        bus_wait = 1'b0;
        forever begin
            @(negedge clk);
            bus_wait = ($urandom() % 3) == 0;
        end
    end

    // monitor
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (bus_req && !bus_wait) begin
                if (bus_q.size() == 0)
                    chk(1'b0, "R6/R7 unexpected bus access", bus_addr, 32'd0);
                else begin
                    bus_t e;
                    e = bus_q.pop_front();
                    chk(bus_addr == e.addr, {"R1/R2 bus_addr ", e.tag}, bus_addr, e.addr);
                    chk(bus_width == e.width, {"R4 bus_width ", e.tag}, 32'(bus_width), 32'(e.width));
                    chk(bus_we == e.we, {"R5 bus_we ", e.tag}, 32'(bus_we), 32'(e.we));
                    if (e.we)
                        chk(bus_wdata == e.wdata, {"R5 bus_wdata ", e.tag}, bus_wdata, e.wdata);
                end
            end
            if (!done && (rd_we || wb_we || align_fault))
                chk(1'b0, "R8 write or fault outside done", 32'({rd_we, wb_we, align_fault}), 32'd0);
            if (done) begin
                if (res_q.size() == 0)
                    chk(1'b0, "R10 unexpected done", 32'd1, 32'd0);
                else begin
                    res_t e;
                    e = res_q.pop_front();
                    chk(align_fault == e.fault, {"R6 align_fault ", e.tag}, 32'(align_fault), 32'(e.fault));
                    chk(rd_we == e.rwe, {"R5/R7 rd_we ", e.tag}, 32'(rd_we), 32'(e.rwe));
                    if (e.rwe) begin
                        chk(rd_addr == e.ra, {"R4 rd_addr ", e.tag}, 32'(rd_addr), 32'(e.ra));
                        chk(rd_data == e.rd, {"R4 rd_data ", e.tag}, rd_data, e.rd);
                    end
                    chk(wb_we == e.wwe, {"R3/R9 wb_we ", e.tag}, 32'(wb_we), 32'(e.wwe));
                    if (e.wwe) begin
                        chk(wb_addr == e.wa, {"R3 wb_addr ", e.tag}, 32'(wb_addr), 32'(e.wa));
                        chk(wb_data == e.wd, {"R3 wb_data ", e.tag}, wb_data, e.wd);
                    end
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !bus_req && !done && !rd_we && !wb_we && !align_fault,
            "R10 reset state", 32'({busy, bus_req, done, rd_we, wb_we, align_fault}), 32'd0);

        // R1/R2: register offset, pre-indexed long load
        issue(mk(0,0,1, 4'd2, 4'd1, 4'd3, 2'd2, 0,0, 13'd5), 32'h0000_1000, 32'h40, 32'h0, 32'h1, "r1_reg_pre");
        // R1/R2/R3: short negative constant, post-indexed byte load with write-back
        issue(mk(0,1,0, 4'd4, 4'd1, 4'd5, 2'd0, 0,1, 13'hF), 32'h0000_2003, 32'h0, 32'h0, 32'h7, "r2_post_byte");
        // R1/R3/R4: long negative constant, pre-indexed half load
        issue(mk(0,1,1, 4'd6, 4'd1, 4'd7, 2'd1, 1,0, 13'h1FFE), 32'h0000_3004, 32'h0, 32'h0, 32'h1, "r4_half_imm13");
        // R5: stores of every size
        issue(mk(1,0,1, 4'd8, 4'd1, 4'd9, 2'd0, 0,1, 13'd1), 32'h0000_4000, 32'h0, 32'hCAFE_BEA5, 32'h1, "r5_store_byte");
        issue(mk(1,1,0, 4'd8, 4'd1, 4'd9, 2'd1, 0,1, 13'd2), 32'h0000_4002, 32'h0, 32'h1234_5678, 32'h1, "r5_store_half");
        issue(mk(1,0,1, 4'd8, 4'd1, 4'd9, 2'd2, 0,0, 13'd0), 32'h0000_4000, 32'h8, 32'h8765_4321, 32'h1, "r5_store_long");
        // R6: faults
        issue(mk(0,1,1, 4'd1, 4'd1, 4'd2, 2'd3, 0,1, 13'd0), 32'h0000_5000, 32'h0, 32'h0, 32'h1, "r6_bad_size");
        issue(mk(0,1,1, 4'd1, 4'd1, 4'd2, 2'd1, 0,1, 13'd1), 32'h0000_5000, 32'h0, 32'h0, 32'h1, "r6_odd_half");
        issue(mk(1,0,0, 4'd1, 4'd1, 4'd2, 2'd2, 0,1, 13'd0), 32'h0000_5002, 32'h0, 32'h0, 32'h1, "r6_long_mis");
        // R7: predicate false
        issue(mk(0,1,1, 4'd1, 4'd3, 4'd2, 2'd2, 0,1, 13'd4), 32'h0000_6000, 32'h0, 32'h0, 32'h0, "r7_skip");
        // R9: load with write-back into its own base register; then store with the same
        issue(mk(0,1,1, 4'd5, 4'd1, 4'd5, 2'd2, 0,1, 13'd4), 32'h0000_7000, 32'h0, 32'h0, 32'h1, "r9_load_wins");
        issue(mk(1,1,1, 4'd5, 4'd1, 4'd5, 2'd2, 0,1, 13'd4), 32'h0000_7000, 32'h0, 32'h55AA_33CC, 32'h1, "r9_store_same");

        // R8: mixed stream under random stretching
        for (int n = 0; n < 300; n++) begin
            logic [31:0] w;
            w = $urandom();
            w[31] = 1'b1;
            issue(w, $urandom() & 32'h000F_FFFF, $urandom() & 32'h0000_00FF, $urandom(),
                  (($urandom() % 8) == 0) ? 32'h0 : $urandom() | 32'h1, "r8_stream");
        end

        @(negedge clk);
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(res_q.size() == 0 && bus_q.size() == 0, "R10 all items retired",
            32'(res_q.size() + bus_q.size()), 32'd0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule